// File: doc/BRIEF.md
# Peak-Detect Slow-Loop Gain Controller

This block runs the slow loop of a receive automatic gain control. Two families of peak detectors sit upstream: a peak family with a high and a low level, and an overload family with a high, a low and a very-low level. Each one raises a per-sample event flag when its level is crossed. The block counts these events per level and turns them into gain changes. It lowers the 8-bit gain index (an attack) when signals run hot, and raises it (a recovery) when they stay quiet. The result is held between a configured floor and ceiling.

The loop works in periods of a programmable number of samples. An attack either fires on the sample after its count is reached (fast mode) or waits for the end of the period. Recoveries only ever happen at the end of a period. After every gain change, detector events are ignored for a settling time. After the loop is switched on, they are ignored for a start-up wait. When the receiver is switched off, a configuration bit chooses whether the loop returns to its ceiling or keeps its state.

Top module: `agc_peak_loop`

## Requirements
- R1: While reset is asserted, `gain_idx` equals the parameter `GAIN_RST` (default 255) and `gain_chg` is 0.
- R2: Each of the five levels has an 8-bit event count that increases by one per counted event and saturates. The count is "reached" when it is at least its limit; a limit of 0 disables that level. A count below its limit keeps its value from one burst of events to the next.
- R3: An attack lowers the index by the step of its family. If the peak family is eligible it is used, otherwise the overload family is used.
- R4: With fast mode set for a family, an attack is applied on the sample after that family's high count is reached. With fast mode clear, the attack waits for the next period expiry.
- R5: A recovery is applied only at a period expiry. The very-low overload step takes priority, then the low overload step, then the low peak step. If an attack is also due at that expiry, only the attack is applied.
- R6: All five counts clear at every period expiry and after every applied action.
- R7: After a change of the index, events are ignored for `settle_len` samples.
- R8: After the loop is enabled, events are ignored for `start_wait` samples, with a floor of 2.
- R9: Every new index is clamped to [`gain_min`, `gain_max`]. `gain_chg` is a one-cycle pulse that occurs only when the index actually changes.
- R10: While `agc_on` is 0: with `rst_on_dis` = 1 the index loads `gain_max` and all counts clear; with `rst_on_dis` = 0 the index is held.
- R11: Period expiry occurs on every `upd_period`-th sample, counted from the sample after the loop is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | IQ-rate sample strobe |
| agc_on | input | 1 | Loop/receiver enable |
| rst_on_dis | input | 1 | 1: loop state resets while disabled |
| evt_pk_hi | input | 1 | Peak detector above high level |
| evt_pk_lo | input | 1 | Peak detector below low level |
| evt_ov_hi | input | 1 | Overload detector above high level |
| evt_ov_lo | input | 1 | Overload detector below low level |
| evt_ov_vlo | input | 1 | Overload detector below very-low level |
| lim_pk_hi | input | 8 | Event limit, peak high |
| lim_pk_lo | input | 8 | Event limit, peak low |
| lim_ov_hi | input | 8 | Event limit, overload high |
| lim_ov_lo | input | 8 | Event limit, overload low |
| lim_ov_vlo | input | 8 | Event limit, overload very-low |
| stp_pk_atk | input | 5 | Peak attack step |
| stp_pk_rec | input | 5 | Peak recovery step |
| stp_ov_atk | input | 5 | Overload attack step |
| stp_ov_rec | input | 5 | Overload low recovery step |
| stp_ov_vrec | input | 5 | Overload very-low recovery step |
| fast_pk | input | 1 | Fast attack, peak family |
| fast_ov | input | 1 | Fast attack, overload family |
| upd_period | input | 22 | Update period in samples |
| settle_len | input | 7 | Settling samples after a change |
| start_wait | input | 5 | Samples ignored after enable |
| gain_min | input | 8 | Index floor |
| gain_max | input | 8 | Index ceiling |
| gain_idx | output | 8 | Current gain index |
| gain_chg | output | 1 | One-cycle pulse on an index change |

## Verification
The bench builds the block with its default parameters: 8-bit index and counts, 5-bit steps, a 22-bit period and a wait floor of 2. Nothing in the block limits runtime timing, so the bench programs short periods (40 samples) and short settling and waits at run time. This lets many period expiries, priority clashes between attack and recovery, and clamps at both rails happen within a few hundred cycles. One phase sets a period of a million samples, so fast attacks there are observed with no expiry anywhere in the window.

// File: rtl/agc_peak_pkg.sv
`timescale 1ns/1ps
package agc_peak_pkg;
  localparam int NUM_THR = 5;
  // Level slots; the decision logic ranks them by these positions.
  localparam int PK_HI  = 0;
  localparam int PK_LO  = 1;
  localparam int OV_HI  = 2;
  localparam int OV_LO  = 3;
  localparam int OV_VLO = 4;

  typedef struct packed {
    logic fire;
    logic up;
  } act_t;
endpackage

// File: rtl/agc_peak_exc_cnt.sv
`timescale 1ns/1ps
module agc_peak_exc_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             reached
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                        cnt_d = '0;
    else if (inc && cnt_q != CNT_TOP) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign reached = (limit != '0) && (cnt_q >= limit);

  assert_cnt_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_TOP && inc && !clr) |=> cnt_q == CNT_TOP);
endmodule

// File: rtl/agc_peak_tbase.sv
`timescale 1ns/1ps
module agc_peak_tbase #(
  parameter int PER_W    = 22,
  parameter int SET_W    = 7,
  parameter int WAIT_W   = 5,
  parameter int MIN_WAIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              agc_on,
  input  logic              smp_en,
  input  logic              flush,
  input  logic [PER_W-1:0]  period,
  input  logic [SET_W-1:0]  settle_len,
  input  logic [WAIT_W-1:0] start_wait,
  input  logic              load_settle,
  output logic              start,
  output logic              run,
  output logic              tick,
  output logic              live
);
  localparam int HOLD_W = (SET_W > WAIT_W) ? SET_W : WAIT_W;
  localparam logic [WAIT_W-1:0] WAIT_FLOOR = WAIT_W'(MIN_WAIT);

  logic              en_q;
  logic [PER_W-1:0]  per_q, per_d, per_last;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic [WAIT_W-1:0] wait_eff;

  assign start    = agc_on && !en_q;
  assign run      = agc_on && smp_en && !start;
  assign per_last = (period == '0) ? '0 : period - 1'b1;
  assign tick     = run && (per_q >= per_last);
  assign live     = (hold_q == '0);
  assign wait_eff = (start_wait < WAIT_FLOOR) ? WAIT_FLOOR : start_wait;

  always_comb begin
    per_d  = per_q;
    hold_d = hold_q;
    if (start) begin
      per_d  = '0;
      hold_d = HOLD_W'(wait_eff);
    end else if (flush) begin
      per_d  = '0;
    end else if (run) begin
      per_d = tick ? '0 : per_q + 1'b1;
      if (load_settle)          hold_d = HOLD_W'(settle_len);
      else if (hold_q != '0)    hold_d = hold_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      per_q  <= '0;
      hold_q <= '0;
    end else begin
      en_q   <= agc_on;
      per_q  <= per_d;
      hold_q <= hold_d;
    end
  end

  assert_wait_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> hold_q >= HOLD_W'(MIN_WAIT));
  assert_tick_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> per_q == '0);
endmodule

// File: rtl/agc_peak_decide.sv
`timescale 1ns/1ps
module agc_peak_decide
  import agc_peak_pkg::*;
#(
  parameter int STEP_W = 5
) (
  input  logic [NUM_THR-1:0] reached,
  input  logic               fast_pk,
  input  logic               fast_ov,
  input  logic               tick,
  input  logic               run,
  input  logic [STEP_W-1:0]  stp_pk_atk,
  input  logic [STEP_W-1:0]  stp_pk_rec,
  input  logic [STEP_W-1:0]  stp_ov_atk,
  input  logic [STEP_W-1:0]  stp_ov_rec,
  input  logic [STEP_W-1:0]  stp_ov_vrec,
  output act_t               act,
  output logic [STEP_W-1:0]  step
);
  logic pk_go, ov_go, atk_due, rec_due;

  assign pk_go   = reached[PK_HI] && (fast_pk || tick);
  assign ov_go   = reached[OV_HI] && (fast_ov || tick);
  assign atk_due = run && (pk_go || ov_go);
  assign rec_due = run && tick && !atk_due &&
                   (reached[OV_VLO] || reached[OV_LO] || reached[PK_LO]);

  always_comb begin
    act.fire = atk_due || rec_due;
    act.up   = rec_due;
    step     = '0;
    if (atk_due)              step = pk_go ? stp_pk_atk : stp_ov_atk;
    else if (reached[OV_VLO]) step = stp_ov_vrec;
    else if (reached[OV_LO])  step = stp_ov_rec;
    else if (reached[PK_LO])  step = stp_pk_rec;
  end
endmodule

// File: rtl/agc_peak_loop.sv
`timescale 1ns/1ps
module agc_peak_loop
  import agc_peak_pkg::*;
#(
  parameter int              GAIN_W   = 8,
  parameter int              STEP_W   = 5,
  parameter int              CNT_W    = 8,
  parameter int              PER_W    = 22,
  parameter int              SET_W    = 7,
  parameter int              WAIT_W   = 5,
  parameter int              MIN_WAIT = 2,
  parameter logic [GAIN_W-1:0] GAIN_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_en,
  input  logic              agc_on,
  input  logic              rst_on_dis,
  input  logic              evt_pk_hi,
  input  logic              evt_pk_lo,
  input  logic              evt_ov_hi,
  input  logic              evt_ov_lo,
  input  logic              evt_ov_vlo,
  input  logic [CNT_W-1:0]  lim_pk_hi,
  input  logic [CNT_W-1:0]  lim_pk_lo,
  input  logic [CNT_W-1:0]  lim_ov_hi,
  input  logic [CNT_W-1:0]  lim_ov_lo,
  input  logic [CNT_W-1:0]  lim_ov_vlo,
  input  logic [STEP_W-1:0] stp_pk_atk,
  input  logic [STEP_W-1:0] stp_pk_rec,
  input  logic [STEP_W-1:0] stp_ov_atk,
  input  logic [STEP_W-1:0] stp_ov_rec,
  input  logic [STEP_W-1:0] stp_ov_vrec,
  input  logic              fast_pk,
  input  logic              fast_ov,
  input  logic [PER_W-1:0]  upd_period,
  input  logic [SET_W-1:0]  settle_len,
  input  logic [WAIT_W-1:0] start_wait,
  input  logic [GAIN_W-1:0] gain_min,
  input  logic [GAIN_W-1:0] gain_max,
  output logic [GAIN_W-1:0] gain_idx,
  output logic              gain_chg
);
  localparam int EXT_W = GAIN_W + 1;

  logic               start, run, tick, live, flush, clr_all;
  logic [NUM_THR-1:0] evt_v, reached;
  logic [CNT_W-1:0]   lim_v [NUM_THR];
  act_t               act;
  logic [STEP_W-1:0]  step;
  logic [GAIN_W-1:0]  gain_q, gain_d, gain_new;
  logic               chg_q, chg_d;
  logic [EXT_W-1:0]   g_ext, s_ext, raw;

  assign evt_v = {evt_ov_vlo, evt_ov_lo, evt_ov_hi, evt_pk_lo, evt_pk_hi};
  assign lim_v[PK_HI]  = lim_pk_hi;
  assign lim_v[PK_LO]  = lim_pk_lo;
  assign lim_v[OV_HI]  = lim_ov_hi;
  assign lim_v[OV_LO]  = lim_ov_lo;
  assign lim_v[OV_VLO] = lim_ov_vlo;

  assign flush   = !agc_on && rst_on_dis;
  assign clr_all = start || flush || (run && (tick || act.fire));

  for (genvar i = 0; i < NUM_THR; i++) begin : g_cnt
    agc_peak_exc_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (run && live && evt_v[i]),
      .clr     (clr_all),
      .limit   (lim_v[i]),
      .reached (reached[i])
    );
  end

  agc_peak_tbase #(
    .PER_W(PER_W), .SET_W(SET_W), .WAIT_W(WAIT_W), .MIN_WAIT(MIN_WAIT)
  ) u_tbase (
    .clk         (clk),
    .rst_n       (rst_n),
    .agc_on      (agc_on),
    .smp_en      (smp_en),
    .flush       (flush),
    .period      (upd_period),
    .settle_len  (settle_len),
    .start_wait  (start_wait),
    .load_settle (chg_d),
    .start       (start),
    .run         (run),
    .tick        (tick),
    .live        (live)
  );

  agc_peak_decide #(.STEP_W(STEP_W)) u_decide (
    .reached     (reached),
    .fast_pk     (fast_pk),
    .fast_ov     (fast_ov),
    .tick        (tick),
    .run         (run),
    .stp_pk_atk  (stp_pk_atk),
    .stp_pk_rec  (stp_pk_rec),
    .stp_ov_atk  (stp_ov_atk),
    .stp_ov_rec  (stp_ov_rec),
    .stp_ov_vrec (stp_ov_vrec),
    .act         (act),
    .step        (step)
  );

  // Step arithmetic one bit wider than the index, then clamp to the rails.
  always_comb begin
    g_ext = {1'b0, gain_q};
    s_ext = EXT_W'(step);
    if (act.up)              raw = g_ext + s_ext;
    else if (g_ext >= s_ext) raw = g_ext - s_ext;
    else                     raw = '0;
    if (raw > {1'b0, gain_max})      gain_new = gain_max;
    else if (raw < {1'b0, gain_min}) gain_new = gain_min;
    else                             gain_new = raw[GAIN_W-1:0];
  end

  always_comb begin
    gain_d = gain_q;
    chg_d  = 1'b0;
    if (flush) begin
      gain_d = gain_max;
    end else if (act.fire) begin
      gain_d = gain_new;
      chg_d  = (gain_new != gain_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= GAIN_RST;
      chg_q  <= 1'b0;
    end else begin
      gain_q <= gain_d;
      chg_q  <= chg_d;
    end
  end

  assign gain_idx = gain_q;
  assign gain_chg = chg_q;

  assert_quiet_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !live) |-> !act.fire);
  assert_rec_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act.fire && act.up) |-> tick);
  assert_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gain_chg |-> (gain_idx >= $past(gain_min) && gain_idx <= $past(gain_max)));
  assert_chg_real_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gain_chg |-> gain_idx != $past(gain_idx));
  assert_dis_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!agc_on && rst_on_dis) |=> gain_idx == $past(gain_max));
endmodule

// File: tb/agc_peak_loop_bench.sv
`timescale 1ns/1ps
module agc_peak_loop_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, smp_en, agc_on, rst_on_dis;
  logic evt_pk_hi, evt_pk_lo, evt_ov_hi, evt_ov_lo, evt_ov_vlo;
  logic [7:0] lim_pk_hi, lim_pk_lo, lim_ov_hi, lim_ov_lo, lim_ov_vlo;
  logic [4:0] stp_pk_atk, stp_pk_rec, stp_ov_atk, stp_ov_rec, stp_ov_vrec;
  logic fast_pk, fast_ov;
  logic [21:0] upd_period;
  logic [6:0] settle_len;
  logic [4:0] start_wait;
  logic [7:0] gain_min, gain_max, gain_idx;
  logic gain_chg;

  agc_peak_loop u_agc_peak_loop (.*);

  int total = 0, bad = 0, t = 0;
  bit done = 1'b0;

  // event mask bits: 0 pk_hi, 1 pk_lo, 2 ov_hi, 3 ov_lo, 4 ov_vlo
  localparam logic [4:0] M_PKHI = 5'b00001, M_PKLO = 5'b00010,
                         M_OVHI = 5'b00100, M_OVLO = 5'b01000, M_VLO = 5'b10000;

  // {mask, samples asserted, expected index}; fast attack on, no expiry
  localparam logic [20:0] VEC [12] = '{
    {5'b00001, 8'd3,  8'd251}, {5'b00100, 8'd2,  8'd244},
    {5'b00001, 8'd2,  8'd244}, {5'b00001, 8'd1,  8'd240},
    {5'b00100, 8'd1,  8'd240}, {5'b00100, 8'd1,  8'd233},
    {5'b00101, 8'd3,  8'd226}, {5'b00001, 8'd20, 8'd218},
    {5'b00001, 8'd1,  8'd214}, {5'b00100, 8'd2,  8'd207},
    {5'b00100, 8'd2,  8'd200}, {5'b00100, 8'd2,  8'd200}};

  task automatic step();
    @(negedge clk);
    t++;
  endtask

  task automatic goto(input int k);
    while (t < k) step();
  endtask

  task automatic set_evt(input logic [4:0] m);
    {evt_ov_vlo, evt_ov_lo, evt_ov_hi, evt_pk_lo, evt_pk_hi} = m;
  endtask

  task automatic pulse(input logic [4:0] m, input int at, input int n);
    goto(at);
    set_evt(m);
    repeat (n) step();
    set_evt(5'b0);
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0d)", req, act, exp, t);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset index", gain_idx, 255);
    check("R1 reset pulse", gain_chg, 0);
    rst_n = 1'b1;
    t = 0;
  endtask

  initial begin
    smp_en = 1'b1; agc_on = 1'b1; rst_on_dis = 1'b0;
    set_evt(5'b0);
    lim_pk_hi = 8'd3; lim_pk_lo = 8'd2; lim_ov_hi = 8'd2; lim_ov_lo = 8'd2; lim_ov_vlo = 8'd2;
    stp_pk_atk = 5'd4; stp_pk_rec = 5'd2; stp_ov_atk = 5'd7; stp_ov_rec = 5'd3; stp_ov_vrec = 5'd6;
    fast_pk = 1'b1; fast_ov = 1'b1;
    upd_period = 22'd1000000; settle_len = 7'd5; start_wait = 5'd3;
    gain_min = 8'd200; gain_max = 8'd255;
    do_reset();
    goto(10);
    // R2 R3 R4 R7 R9: fast attacks, persistence, settle gaps, floor clamp
    for (int i = 0; i < 12; i++) begin
      set_evt(VEC[i][20:16]);
      repeat (int'(VEC[i][15:8])) step();
      set_evt(5'b0);
      repeat (12) step();
      check($sformatf("R2/R3/R4/R7/R9 vector %0d", i), gain_idx, int'(VEC[i][7:0]));
    end

    // Deferred mode with a 40-sample period
    fast_pk = 1'b0; fast_ov = 1'b0; upd_period = 22'd40;
    stp_pk_atk = 5'd20;
    do_reset();
    pulse(M_PKHI, 10, 3);
    goto(20); check("R4 attack deferred", gain_idx, 255);
    pulse(M_PKLO, 30, 2);
    goto(40); check("R11 before expiry", gain_idx, 255);
    goto(41); check("R5 attack wins at expiry", gain_idx, 235);
    check("R9 change pulse", gain_chg, 1);
    goto(42); check("R9 pulse one cycle", gain_chg, 0);
    pulse(M_VLO, 50, 2); pulse(M_OVLO, 52, 2); pulse(M_PKLO, 54, 2);
    goto(81); check("R5 very-low step first", gain_idx, 241);
    pulse(M_OVLO, 90, 2);
    goto(121); check("R5 overload low step", gain_idx, 244);
    pulse(M_PKLO, 130, 2);
    goto(161); check("R5 peak low step", gain_idx, 246);
    pulse(M_PKLO, 170, 1);
    goto(201); check("R6 below limit", gain_idx, 246);
    pulse(M_PKLO, 210, 1);
    goto(241); check("R6 cleared at expiry", gain_idx, 246);
    goto(245); gain_max = 8'd250;
    pulse(M_VLO, 250, 2);
    goto(281); check("R9 ceiling clamp", gain_idx, 250);
    pulse(M_PKHI, 281, 3);
    goto(321); check("R7 settle ignores events", gain_idx, 250);
    goto(325); gain_min = 8'd240;
    pulse(M_PKHI, 330, 3);
    goto(361); check("R9 floor clamp", gain_idx, 240);

    // Disable behaviour and start-up wait
    goto(370); agc_on = 1'b0;
    repeat (10) step();
    check("R10 keep state", gain_idx, 240);
    agc_on = 1'b1; t = 0;
    goto(20);
    rst_on_dis = 1'b1; agc_on = 1'b0;
    step();
    check("R10 load ceiling", gain_idx, 250);
    fast_pk = 1'b1; lim_pk_hi = 8'd1; start_wait = 5'd0;
    agc_on = 1'b1; t = 0;
    pulse(M_PKHI, 1, 2);
    goto(8); check("R8 wait floor ignores events", gain_idx, 250);
    pulse(M_PKHI, 8, 1);
    goto(10); check("R8 live after wait", gain_idx, 240);
    check("R8 change pulse", gain_chg, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule